// File: doc/BRIEF.md
# Mailbox Abort and Status Controller

This block holds the handshake state shared by a host-side requester and a firmware-side responder of a message mailbox. The host can abort a transfer, announce that a request object is complete ("go"), acknowledge a response word, and enable its interrupt and asynchronous-message features. Firmware can raise or clear an error, announce that a response object is ready, request an asynchronous message, and finish abort handling. Data storage, address pointers and register decoding sit outside the block. Each register access reaches the block as a one-cycle strobe with level data.

The block produces a 5-bit host status word and a host interrupt line. Toward firmware it produces a 6-bit control/status view and three interrupt sources (ready, abort, error). Each source has its own state bit, enable bit, clear strobe and test strobe. An abort is a two-party sequence. The host request raises busy and wipes error, ready and async state. Busy then stays high until firmware acknowledges completion.

Top module: `mbx_handshake_ctrl`

## Requirements
- R1: After reset, host_status_o is 5'b00001 (busy = 1; error, ready, async and interrupt status = 0). fw_view_o is 6'b000001. fw_irq_state_o, fw_irq_o and host_irq_o are 0.
- R2: A host_abort_i strobe sets busy (host_status_o[0]) and the abort alias (fw_view_o[4]) from the next cycle on. Both stay set until a cycle with fw_ctrl_wr_i = 1, fw_abort_i = 0 and no host abort; that cycle clears both. A firmware write with fw_abort_i = 1 changes neither.
- R3: A host_abort_i strobe clears error, ready and async status in the next cycle, even when a set request arrives in the same cycle.
- R4: Error (host_status_o[1]) is set by host_bad_access_i or by a firmware control write with fw_error_i = 1. A firmware control write with fw_error_i = 0 clears it, unless a set arrives in the same cycle.
- R5: Ready (host_status_o[2]) is set by fw_ready_set_i and cleared by host_ready_done_i. A set wins over a clear in the same cycle.
- R6: Async status (host_status_o[3]) is set by fw_async_req_i only while the registered host async enable (fw_view_o[3]) is 1. It is held at 0 while that enable is 0.
- R7: A 0-to-1 change of ready, error or async status sets the host interrupt status (host_status_o[4]) in the same cycle that the status bit changes.
- R8: host_intr_clr_i clears the host interrupt status, unless a new event occurs in the same cycle.
- R9: host_irq_o is 1 exactly when the host interrupt status is 1 and the host interrupt enable (fw_view_o[2]) is 1. host_ctrl_wr_i loads the interrupt enable and the async enable from host_intr_en_i and host_async_en_i.
- R10: fw_view_o bits are [0] busy, [1] host interrupt status, [2] host interrupt enable, [3] host async enable, [4] abort alias, [5] error.
- R11: fw_irq_state_o bit 0 (ready) is set by host_go_i, bit 1 (abort) by host_abort_i, and bit 2 (error) by a 0-to-1 change of error. fw_irq_test_i forces a bit to 1. fw_irq_clr_i clears it, and a set or test wins over a clear.
- R12: fw_irq_o[k] = fw_irq_state_o[k] AND the enable bit k. fw_irq_en_wr_i loads the enable bits from fw_irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_ctrl_wr_i | input | 1 | Host control write strobe (loads enables) |
| host_intr_en_i | input | 1 | Host interrupt enable write data |
| host_async_en_i | input | 1 | Host async-message enable write data |
| host_abort_i | input | 1 | Host abort request strobe |
| host_go_i | input | 1 | Host request-object-complete strobe |
| host_intr_clr_i | input | 1 | Host write-1-to-clear of interrupt status |
| host_bad_access_i | input | 1 | Invalid host data-register access strobe |
| host_ready_done_i | input | 1 | Host has consumed the response object |
| fw_ctrl_wr_i | input | 1 | Firmware control write strobe |
| fw_abort_i | input | 1 | Firmware abort alias write data |
| fw_error_i | input | 1 | Firmware error write data |
| fw_async_req_i | input | 1 | Firmware async-message request strobe |
| fw_ready_set_i | input | 1 | Firmware response-ready strobe |
| fw_irq_en_wr_i | input | 1 | Firmware interrupt enable write strobe |
| fw_irq_en_i | input | 3 | Firmware interrupt enable write data |
| fw_irq_clr_i | input | 3 | Firmware interrupt write-1-to-clear |
| fw_irq_test_i | input | 3 | Firmware interrupt test (force to 1) |
| host_status_o | output | 5 | {intr, async, ready, error, busy} |
| host_irq_o | output | 1 | Host interrupt |
| fw_view_o | output | 6 | Firmware control/status view |
| fw_irq_state_o | output | 3 | Firmware interrupt state {error, abort, ready} |
| fw_irq_o | output | 3 | Enabled firmware interrupts |

## Verification
On every cycle, the assertions check four things. An abort raises busy and clears error, ready and async. Busy holds until firmware releases it. Async stays low while disabled. Events, tests and clears drive the interrupt state bits in the right direction. Three behaviours are shown only by the bench's reference model, which is compared on every clock: the priority between same-cycle set and clear requests, the exact makeup of both status words, and the interaction of a random mix of host and firmware requests over a long run.

// File: rtl/mbx_hs_pkg.sv
package mbx_hs_pkg;
  localparam int unsigned FwIrqN    = 3;
  localparam int unsigned IrqReady  = 0;
  localparam int unsigned IrqAbort  = 1;
  localparam int unsigned IrqError  = 2;

  localparam int unsigned HostEvtN  = 3;  // ready, error, async rises
  localparam int unsigned EvtReady  = 0;
  localparam int unsigned EvtError  = 1;
  localparam int unsigned EvtAsync  = 2;

  localparam int unsigned HostStatW = 5;
  localparam int unsigned StBusy    = 0;
  localparam int unsigned StError   = 1;
  localparam int unsigned StReady   = 2;
  localparam int unsigned StAsync   = 3;
  localparam int unsigned StIntr    = 4;

  localparam int unsigned FwViewW   = 6;
  localparam int unsigned FvBusy    = 0;
  localparam int unsigned FvIntr    = 1;
  localparam int unsigned FvIntrEn  = 2;
  localparam int unsigned FvAsyncEn = 3;
  localparam int unsigned FvAbort   = 4;
  localparam int unsigned FvError   = 5;
endpackage

// File: rtl/mbx_hs_state.sv
module mbx_hs_state
  import mbx_hs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_abort_i,
  input  logic                host_bad_access_i,
  input  logic                host_ready_done_i,
  input  logic                fw_ctrl_wr_i,
  input  logic                fw_abort_i,
  input  logic                fw_error_i,
  input  logic                fw_ready_set_i,
  input  logic                fw_async_req_i,
  input  logic                async_en_i,
  output logic                busy_o,
  output logic                abort_o,
  output logic                error_o,
  output logic                ready_o,
  output logic                async_o,
  output logic [HostEvtN-1:0] rise_o
);
  logic busy_q, abort_q, error_q, ready_q, async_q;
  logic busy_d, abort_d, error_d, ready_d, async_d;
  logic release_w;

  assign release_w = fw_ctrl_wr_i && !fw_abort_i;

  always_comb begin
    busy_d  = busy_q;
    abort_d = abort_q;
    if (host_abort_i) begin
      busy_d  = 1'b1;
      abort_d = 1'b1;
    end else if (release_w) begin
      busy_d  = 1'b0;
      abort_d = 1'b0;
    end

    error_d = error_q;
    if (host_abort_i)                                error_d = 1'b0;
    else if (host_bad_access_i || (fw_ctrl_wr_i && fw_error_i)) error_d = 1'b1;
    else if (fw_ctrl_wr_i)                           error_d = 1'b0;

    ready_d = ready_q;
    if (host_abort_i)           ready_d = 1'b0;
    else if (fw_ready_set_i)    ready_d = 1'b1;
    else if (host_ready_done_i) ready_d = 1'b0;

    async_d = async_q;
    if (host_abort_i || !async_en_i) async_d = 1'b0;
    else if (fw_async_req_i)         async_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b1;
      abort_q <= 1'b0;
      error_q <= 1'b0;
      ready_q <= 1'b0;
      async_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      abort_q <= abort_d;
      error_q <= error_d;
      ready_q <= ready_d;
      async_q <= async_d;
    end
  end

  // events are flagged in the cycle the bit is about to rise
  assign rise_o[EvtReady] = ready_d && !ready_q;
  assign rise_o[EvtError] = error_d && !error_q;
  assign rise_o[EvtAsync] = async_d && !async_q;

  assign busy_o  = busy_q;
  assign abort_o = abort_q;
  assign error_o = error_q;
  assign ready_o = ready_q;
  assign async_o = async_q;

  p_abort_sets_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_abort_i |=> busy_q && abort_q);

  p_busy_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !(fw_ctrl_wr_i && !fw_abort_i) |=> busy_q);

  p_abort_wipes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_abort_i |=> !error_q && !ready_q && !async_q);

  p_async_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !async_en_i |=> !async_q);
endmodule

// File: rtl/mbx_hs_host_intr.sv
module mbx_hs_host_intr #(
  parameter int unsigned NumEvt = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NumEvt-1:0] evt_i,
  input  logic              clr_i,
  input  logic              en_i,
  output logic              intr_o,
  output logic              irq_o
);
  logic intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      intr_q <= 1'b0;
    else if (|evt_i)  intr_q <= 1'b1;
    else if (clr_i)   intr_q <= 1'b0;
  end

  assign intr_o = intr_q;
  assign irq_o  = intr_q && en_i;

  p_event_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> intr_q);

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(|evt_i) |=> !intr_q);
endmodule

// File: rtl/mbx_hs_fw_intr.sv
module mbx_hs_fw_intr #(
  parameter int unsigned NumIrq = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NumIrq-1:0] set_i,
  input  logic [NumIrq-1:0] test_i,
  input  logic [NumIrq-1:0] clr_i,
  input  logic              en_wr_i,
  input  logic [NumIrq-1:0] en_i,
  output logic [NumIrq-1:0] state_o,
  output logic [NumIrq-1:0] irq_o
);
  logic [NumIrq-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_i;
  end

  for (genvar k = 0; k < NumIrq; k++) begin : g_src
    logic st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    st_q <= 1'b0;
      else if (set_i[k] || test_i[k]) st_q <= 1'b1;
      else if (clr_i[k])              st_q <= 1'b0;
    end
    assign state_o[k] = st_q;
    assign irq_o[k]   = st_q && en_q[k];

    p_test_forces_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      test_i[k] |=> st_q);

    p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] && !set_i[k] && !test_i[k] |=> !st_q);
  end
endmodule

// File: rtl/mbx_handshake_ctrl.sv
module mbx_handshake_ctrl
  import mbx_hs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_ctrl_wr_i,
  input  logic                 host_intr_en_i,
  input  logic                 host_async_en_i,
  input  logic                 host_abort_i,
  input  logic                 host_go_i,
  input  logic                 host_intr_clr_i,
  input  logic                 host_bad_access_i,
  input  logic                 host_ready_done_i,
  input  logic                 fw_ctrl_wr_i,
  input  logic                 fw_abort_i,
  input  logic                 fw_error_i,
  input  logic                 fw_async_req_i,
  input  logic                 fw_ready_set_i,
  input  logic                 fw_irq_en_wr_i,
  input  logic [FwIrqN-1:0]    fw_irq_en_i,
  input  logic [FwIrqN-1:0]    fw_irq_clr_i,
  input  logic [FwIrqN-1:0]    fw_irq_test_i,
  output logic [HostStatW-1:0] host_status_o,
  output logic                 host_irq_o,
  output logic [FwViewW-1:0]   fw_view_o,
  output logic [FwIrqN-1:0]    fw_irq_state_o,
  output logic [FwIrqN-1:0]    fw_irq_o
);
  logic intr_en_q, async_en_q;
  logic busy, abort, error, ready, async_st, intr;
  logic [HostEvtN-1:0] evt;
  logic [FwIrqN-1:0]   fw_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_en_q  <= 1'b0;
      async_en_q <= 1'b0;
    end else if (host_ctrl_wr_i) begin
      intr_en_q  <= host_intr_en_i;
      async_en_q <= host_async_en_i;
    end
  end

  mbx_hs_state i_state (
    .clk_i,
    .rst_ni,
    .host_abort_i,
    .host_bad_access_i,
    .host_ready_done_i,
    .fw_ctrl_wr_i,
    .fw_abort_i,
    .fw_error_i,
    .fw_ready_set_i,
    .fw_async_req_i,
    .async_en_i (async_en_q),
    .busy_o     (busy),
    .abort_o    (abort),
    .error_o    (error),
    .ready_o    (ready),
    .async_o    (async_st),
    .rise_o     (evt)
  );

  mbx_hs_host_intr #(.NumEvt(HostEvtN)) i_host_intr (
    .clk_i,
    .rst_ni,
    .evt_i  (evt),
    .clr_i  (host_intr_clr_i),
    .en_i   (intr_en_q),
    .intr_o (intr),
    .irq_o  (host_irq_o)
  );

  always_comb begin
    fw_set           = '0;
    fw_set[IrqReady] = host_go_i;
    fw_set[IrqAbort] = host_abort_i;
    fw_set[IrqError] = evt[EvtError];
  end

  mbx_hs_fw_intr #(.NumIrq(FwIrqN)) i_fw_intr (
    .clk_i,
    .rst_ni,
    .set_i   (fw_set),
    .test_i  (fw_irq_test_i),
    .clr_i   (fw_irq_clr_i),
    .en_wr_i (fw_irq_en_wr_i),
    .en_i    (fw_irq_en_i),
    .state_o (fw_irq_state_o),
    .irq_o   (fw_irq_o)
  );

  always_comb begin
    host_status_o          = '0;
    host_status_o[StBusy]  = busy;
    host_status_o[StError] = error;
    host_status_o[StReady] = ready;
    host_status_o[StAsync] = async_st;
    host_status_o[StIntr]  = intr;

    fw_view_o            = '0;
    fw_view_o[FvBusy]    = busy;
    fw_view_o[FvIntr]    = intr;
    fw_view_o[FvIntrEn]  = intr_en_q;
    fw_view_o[FvAsyncEn] = async_en_q;
    fw_view_o[FvAbort]   = abort;
    fw_view_o[FvError]   = error;
  end
endmodule

// File: tb/test_mbx_handshake_ctrl.sv
`timescale 1ns/1ps
module test_mbx_handshake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic host_ctrl_wr, host_intr_en, host_async_en, host_abort, host_go;
  logic host_intr_clr, host_bad_access, host_ready_done;
  logic fw_ctrl_wr, fw_abort, fw_error, fw_async_req, fw_ready_set, fw_irq_en_wr;
  logic [2:0] fw_irq_en, fw_irq_clr, fw_irq_test;
  logic [4:0] host_status;
  logic       host_irq;
  logic [5:0] fw_view;
  logic [2:0] fw_irq_state, fw_irq;

  mbx_handshake_ctrl i_mbx_handshake_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .host_ctrl_wr_i(host_ctrl_wr), .host_intr_en_i(host_intr_en),
    .host_async_en_i(host_async_en), .host_abort_i(host_abort),
    .host_go_i(host_go), .host_intr_clr_i(host_intr_clr),
    .host_bad_access_i(host_bad_access), .host_ready_done_i(host_ready_done),
    .fw_ctrl_wr_i(fw_ctrl_wr), .fw_abort_i(fw_abort), .fw_error_i(fw_error),
    .fw_async_req_i(fw_async_req), .fw_ready_set_i(fw_ready_set),
    .fw_irq_en_wr_i(fw_irq_en_wr), .fw_irq_en_i(fw_irq_en),
    .fw_irq_clr_i(fw_irq_clr), .fw_irq_test_i(fw_irq_test),
    .host_status_o(host_status), .host_irq_o(host_irq), .fw_view_o(fw_view),
    .fw_irq_state_o(fw_irq_state), .fw_irq_o(fw_irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_abort, m_err, m_rdy, m_async, m_intr, m_ien, m_aen;
  bit [2:0] m_fst, m_fen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1; m_abort = 0; m_err = 0; m_rdy = 0; m_async = 0;
      m_intr = 0; m_ien = 0; m_aen = 0; m_fst = 0; m_fen = 0;
    end else begin
      bit n_busy, n_abort, n_err, n_rdy, n_async, ev, err_up;
      bit [2:0] setv;
      n_busy = m_busy; n_abort = m_abort; n_err = m_err; n_rdy = m_rdy; n_async = m_async;
      if (host_abort) begin n_busy = 1; n_abort = 1; end
      else if (fw_ctrl_wr && !fw_abort) begin n_busy = 0; n_abort = 0; end
      if (host_abort) n_err = 0;
      else if (host_bad_access || (fw_ctrl_wr && fw_error)) n_err = 1;
      else if (fw_ctrl_wr) n_err = 0;
      if (host_abort) n_rdy = 0;
      else if (fw_ready_set) n_rdy = 1;
      else if (host_ready_done) n_rdy = 0;
      if (host_abort || !m_aen) n_async = 0;
      else if (fw_async_req) n_async = 1;
      err_up = n_err && !m_err;
      ev = (n_rdy && !m_rdy) || err_up || (n_async && !m_async);
      if (ev) m_intr = 1; else if (host_intr_clr) m_intr = 0;
      setv = {err_up, host_abort, host_go} | fw_irq_test;
      m_fst = setv | (m_fst & ~fw_irq_clr);
      if (fw_irq_en_wr) m_fen = fw_irq_en;
      if (host_ctrl_wr) begin m_ien = host_intr_en; m_aen = host_async_en; end
      m_busy = n_busy; m_abort = n_abort; m_err = n_err; m_rdy = n_rdy; m_async = n_async;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 busy",        host_status[0], m_busy);
      check("R4 error",       host_status[1], m_err);
      check("R5 ready",       host_status[2], m_rdy);
      check("R6 async",       host_status[3], m_async);
      check("R7 intr",        host_status[4], m_intr);
      check("R9 host_irq",    host_irq, m_intr && m_ien);
      check("R10 fw_view",    fw_view, {m_err, m_abort, m_aen, m_ien, m_intr, m_busy});
      check("R11 irq_state",  fw_irq_state, m_fst);
      check("R12 fw_irq",     fw_irq, m_fst & m_fen);
    end
  end

  task automatic idle();
    host_ctrl_wr = 0; host_abort = 0; host_go = 0; host_intr_clr = 0;
    host_bad_access = 0; host_ready_done = 0; fw_ctrl_wr = 0; fw_async_req = 0;
    fw_ready_set = 0; fw_irq_en_wr = 0; fw_irq_clr = 0; fw_irq_test = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #2; idle();
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    idle();
    host_intr_en = 0; host_async_en = 0; fw_abort = 0; fw_error = 0; fw_irq_en = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    settle();
    check("R1 status",    host_status, 5'b00001);
    check("R1 fw_view",   fw_view, 6'b000001);
    check("R1 irq_state", fw_irq_state, 0);
    check("R1 host_irq",  host_irq, 0);
    @(posedge clk); #2;

    fw_abort = 1; fw_ctrl_wr = 1; cyc(); settle();
    check("R2 fw write 1 keeps busy", host_status[0], 1);
    fw_abort = 0; fw_ctrl_wr = 1; cyc(); settle();
    check("R2 release", host_status[0], 0);

    host_ctrl_wr = 1; host_intr_en = 1; host_async_en = 1; cyc();
    fw_ready_set = 1; cyc(); settle();
    check("R5 ready set", host_status[2], 1);
    check("R7 intr on ready", host_status[4], 1);
    check("R9 host irq", host_irq, 1);

    host_intr_clr = 1; cyc(); settle();
    check("R8 w1c", host_status[4], 0);

    host_bad_access = 1; cyc(); settle();
    check("R4 bad access", host_status[1], 1);
    check("R11 error source", fw_irq_state[2], 1);

    host_abort = 1; fw_async_req = 1; fw_ready_set = 1; cyc(); settle();
    check("R2 abort busy", host_status[0], 1);
    check("R10 abort alias", fw_view[4], 1);
    check("R3 wipe", host_status[3:1], 0);
    check("R11 abort source", fw_irq_state[1], 1);

    fw_ctrl_wr = 1; fw_abort = 0; cyc();
    host_ctrl_wr = 1; host_async_en = 0; cyc();
    fw_async_req = 1; cyc(); settle();
    check("R6 async ignored", host_status[3], 0);

    fw_irq_en_wr = 1; fw_irq_en = 3'b101; fw_irq_test = 3'b001; host_go = 1; cyc(); settle();
    check("R12 enabled irq", fw_irq, 3'b101);
    fw_irq_clr = 3'b111; fw_irq_test = 3'b010; cyc(); settle();
    check("R11 test beats clear", fw_irq_state, 3'b010);

    void'($urandom(7));
    for (int i = 0; i < 4000; i++) begin
      host_abort      = ($urandom % 24) == 0;
      host_go         = ($urandom % 8) == 0;
      host_intr_clr   = ($urandom % 4) == 0;
      host_bad_access = ($urandom % 12) == 0;
      host_ready_done = ($urandom % 5) == 0;
      host_ctrl_wr    = ($urandom % 10) == 0;
      host_intr_en    = $urandom % 2;
      host_async_en   = $urandom % 2;
      fw_ctrl_wr      = ($urandom % 8) == 0;
      fw_abort        = $urandom % 2;
      fw_error        = $urandom % 2;
      fw_async_req    = ($urandom % 4) == 0;
      fw_ready_set    = ($urandom % 6) == 0;
      fw_irq_en_wr    = ($urandom % 16) == 0;
      fw_irq_en       = 3'($urandom);
      fw_irq_clr      = 3'($urandom);
      fw_irq_test     = (($urandom % 8) == 0) ? 3'($urandom) : 3'b0;
      cyc();
    end
    settle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule